// File: doc/BRIEF.md
# DMA Interrupt Coalescing Controller

This block holds the interrupt logic of one channel of a descriptor-driven DMA engine. The descriptor engine sends it a one-cycle pulse each time a descriptor finishes. The block then raises a single level interrupt in two cases. The first is when a programmed number of completions has gathered. The second is when traffic stops and a delay timer, re-armed by every completion, runs out. Software programs a 32-bit control word and clears pending causes by writing ones to a status word. Both words are read back through a plain register port. The status read also shows the live completion count and the live timer value.

The delay timer counts down on a prescaled tick input rather than on the clock, so one delay unit can last many cycles. The timer is a two-state machine. TMR_IDLE means stopped. TMR_RUN means counting. Its transitions are:
- arm: a completion with a non-zero delay field, taking the timer from TMR_IDLE or TMR_RUN to TMR_RUN.
- stop: a completion with a zero delay field, taking the timer from TMR_RUN to TMR_IDLE.
- expire: a tick while the timer holds 1, taking it from TMR_RUN to TMR_IDLE.
- clear: a channel soft reset, sending the timer from any state to TMR_IDLE.

Control word fields:
- bit 0: run
- bit 2: soft reset
- bits 14:12: interrupt enables
- bits 23:16: completion threshold
- bits 31:24: delay value

Status flags:
- bit 12: completion flag
- bit 13: delay flag
- bit 14: a third cause that is stored and can be cleared, but that nothing inside this block sets

Top module: `dma_irq_coalesce`

## Requirements
- R1: After reset, the control word reads 0x0001_0000 (threshold 1), the live count is 1, the timer is 0, all flags are clear and irq_o is low, so the status word reads 0x0001_0000.
- R2: Each completion pulse decrements the live count. When the count before the pulse is 1 or less, the completion flag (status bit 12) is set instead and the count reloads from the threshold field (control bits 23:16).
- R3: A completion with a non-zero delay field (control bits 31:24) loads the timer with that value and starts it. The timer then drops by one per tick pulse. On the tick that takes it from 1 to 0, it stops, sets the delay flag (status bit 13) and reloads the live count from the threshold.
- R4: A completion with a zero delay field leaves the timer stopped at 0. Ticks then change nothing and the delay flag is not set.
- R5: irq_o is high exactly when some status bit among 14:12 is set and the control bit in the same position is also set.
- R6: A status write clears each of bits 14:12 written as 1 and leaves bits written as 0 unchanged. A flag set in the same cycle as its clear stays set.
- R7: A status read returns the timer in bits 31:24, the live count in bits 23:16 and the flags in bits 14:12. All other bits read 0. A control read returns the stored control word.
- R8: A control write with bit 0 set and bit 2 clear reloads the live count from the threshold in the written value. A control write without bit 0 leaves the count unchanged.
- R9: A control write with bit 2 set restores the full R1 state, whatever the other bits written. The run bit in that write therefore has no effect.
- R10: When a timer expiry and a completion fall in the same cycle, the delay flag is still set. The timer restarts from the delay field, and the count is the threshold less one, or the completion flag is set when the threshold is 1 or less.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmpl_i | input | 1 | One-cycle pulse: a descriptor finished |
| tick_i | input | 1 | Prescaled timer tick enable |
| cfg_we_i | input | 1 | Control word write strobe |
| cfg_wdata_i | input | 32 | Control word write data |
| sts_we_i | input | 1 | Status word write strobe (write one to clear) |
| sts_wdata_i | input | 32 | Status word write data |
| cfg_rdata_o | output | 32 | Control word read value |
| sts_rdata_o | output | 32 | Status word read value with live count and timer |
| irq_o | output | 1 | Level interrupt |

## Verification
Two pairs of functions can act in the same cycle. In the first pair, a completion pulse and the timer's final tick coincide: the bench counts the timer down to 1 and then drives cmpl_i and tick_i together. It expects the delay flag set, the timer reloaded to the delay value and the count equal to the threshold less one. In the second pair, a software clear of the completion flag lands in the cycle where a completion sets it: the bench lowers the count to 1 and writes 0x1000 to the status word alongside the pulse. It expects the flag to remain set.

// File: rtl/dic_pkg.sv
package dic_pkg;
    localparam int WORD_W   = 32;
    localparam int RUN_BIT  = 0;
    localparam int SRST_BIT = 2;
    localparam int FLAG_LO  = 12;
    localparam int THR_LO   = 16;
    localparam int DLY_LO   = 24;

    typedef enum logic {
        TMR_IDLE = 1'b0,
        TMR_RUN  = 1'b1
    } tmr_state_e;
endpackage

// File: rtl/dic_cmpl_counter.sv
module dic_cmpl_counter #(
    parameter int CW      = 8,
    parameter int RST_THR = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          reload,
    input  logic [CW-1:0] thr,
    input  logic          cmpl,
    output logic [CW-1:0] cnt,
    output logic          hit
);
    logic [CW-1:0] cnt_q, base, cnt_n;

    always_comb begin
        base = reload ? thr : cnt_q;
        hit  = cmpl && (base <= CW'(1));
        if (clr)
            cnt_n = CW'(RST_THR);
        else if (hit)
            cnt_n = thr;
        else if (cmpl)
            cnt_n = base - CW'(1);
        else
            cnt_n = base;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= CW'(RST_THR);
        else        cnt_q <= cnt_n;
    end

    assign cnt = cnt_q;

    a_r2_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (cmpl && !reload && !clr && cnt_q > CW'(1)) |=> cnt_q == $past(cnt_q) - CW'(1));
    a_r2_hit_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !clr) |=> cnt_q == $past(thr));
endmodule

// File: rtl/dic_delay_timer.sv
module dic_delay_timer
    import dic_pkg::*;
#(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          arm,
    input  logic [TW-1:0] dly,
    input  logic          tick,
    output logic [TW-1:0] tmr,
    output logic          fire
);
    tmr_state_e    state_q, state_n;
    logic [TW-1:0] tmr_q, tmr_n;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TMR_IDLE;
            tmr_q   <= '0;
        end else begin
            state_q <= state_n;
            tmr_q   <= tmr_n;
        end
    end

    // next state and outputs
    always_comb begin
        state_n = state_q;
        tmr_n   = tmr_q;
        fire    = 1'b0;
        unique case (state_q)
            TMR_IDLE: begin
                if (arm && dly != '0) begin
                    state_n = TMR_RUN;
                    tmr_n   = dly;
                end
            end
            TMR_RUN: begin
                fire = tick && (tmr_q == TW'(1));
                if (arm) begin
                    state_n = (dly != '0) ? TMR_RUN : TMR_IDLE;
                    tmr_n   = dly;
                end else if (fire) begin
                    state_n = TMR_IDLE;
                    tmr_n   = '0;
                end else if (tick) begin
                    tmr_n   = tmr_q - TW'(1);
                end
            end
        endcase
        if (clr) begin
            state_n = TMR_IDLE;
            tmr_n   = '0;
        end
    end

    assign tmr = tmr_q;

    a_r3_tick_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TMR_RUN && tick && tmr_q > TW'(1) && !arm && !clr)
        |=> tmr_q == $past(tmr_q) - TW'(1));
    a_r4_zero_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && dly == '0 && !clr) |=> (tmr_q == '0 && state_q == TMR_IDLE));
    a_r10_fire_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && arm && dly != '0 && !clr) |=> (tmr_q == $past(dly) && state_q == TMR_RUN));
endmodule

// File: rtl/dma_irq_coalesce.sv
module dma_irq_coalesce
    import dic_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int TMR_W   = 8,
    parameter int N_FLAG  = 3,
    parameter int RST_THR = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmpl_i,
    input  logic        tick_i,
    input  logic        cfg_we_i,
    input  logic [31:0] cfg_wdata_i,
    input  logic        sts_we_i,
    input  logic [31:0] sts_wdata_i,
    output logic [31:0] cfg_rdata_o,
    output logic [31:0] sts_rdata_o,
    output logic        irq_o
);
    localparam logic [WORD_W-1:0] CFG_RST = WORD_W'(RST_THR) << THR_LO;
    localparam int FLAG_HI = FLAG_LO + N_FLAG - 1;

    logic [WORD_W-1:0] cfg_q, cfg_eff;
    logic [N_FLAG-1:0] flag_q, flag_set, flag_clr;
    logic              soft_rst, run_go, hit, fire;
    logic [CNT_W-1:0]  cnt;
    logic [TMR_W-1:0]  tmr;

    assign cfg_eff  = cfg_we_i ? cfg_wdata_i : cfg_q;
    assign soft_rst = cfg_we_i && cfg_wdata_i[SRST_BIT];
    assign run_go   = cfg_we_i && cfg_wdata_i[RUN_BIT] && !cfg_wdata_i[SRST_BIT];

    dic_cmpl_counter #(.CW(CNT_W), .RST_THR(RST_THR)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (soft_rst),
        .reload (run_go || fire),
        .thr    (cfg_eff[THR_LO +: CNT_W]),
        .cmpl   (cmpl_i),
        .cnt    (cnt),
        .hit    (hit)
    );

    dic_delay_timer #(.TW(TMR_W)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (soft_rst),
        .arm   (cmpl_i),
        .dly   (cfg_eff[DLY_LO +: TMR_W]),
        .tick  (tick_i),
        .tmr   (tmr),
        .fire  (fire)
    );

    always_comb begin
        flag_set    = '0;
        flag_set[0] = hit;
        flag_set[1] = fire;
        flag_clr    = sts_we_i ? sts_wdata_i[FLAG_HI:FLAG_LO] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q  <= CFG_RST;
            flag_q <= '0;
        end else if (soft_rst) begin
            cfg_q  <= CFG_RST;
            flag_q <= '0;
        end else begin
            if (cfg_we_i) cfg_q <= cfg_wdata_i;
            flag_q <= (flag_q & ~flag_clr) | flag_set;
        end
    end

    always_comb begin
        sts_rdata_o                    = '0;
        sts_rdata_o[FLAG_HI:FLAG_LO]   = flag_q;
        sts_rdata_o[THR_LO +: CNT_W]   = cnt;
        sts_rdata_o[DLY_LO +: TMR_W]   = tmr;
        cfg_rdata_o                    = cfg_q;
        irq_o = |(flag_q & cfg_q[FLAG_HI:FLAG_LO]);
    end

    a_r6_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_we_i && sts_wdata_i[FLAG_LO] && !hit) |=> !flag_q[0]);
    a_r9_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (cfg_q == CFG_RST && flag_q == '0 && tmr == '0));
    a_r5_no_enable_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q[FLAG_HI:FLAG_LO] == '0) |-> !irq_o);
endmodule

// File: tb/test_dma_irq_coalesce.sv
`timescale 1ns/1ps
module test_dma_irq_coalesce;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmpl_i = 1'b0, tick_i = 1'b0;
    logic        cfg_we_i = 1'b0, sts_we_i = 1'b0;
    logic [31:0] cfg_wdata_i = '0, sts_wdata_i = '0;
    logic [31:0] cfg_rdata_o, sts_rdata_o;
    logic        irq_o;
    int          n_run = 0, n_fail = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    dma_irq_coalesce i_dma_irq_coalesce (
        .clk(clk), .rst_n(rst_n), .cmpl_i(cmpl_i), .tick_i(tick_i),
        .cfg_we_i(cfg_we_i), .cfg_wdata_i(cfg_wdata_i),
        .sts_we_i(sts_we_i), .sts_wdata_i(sts_wdata_i),
        .cfg_rdata_o(cfg_rdata_o), .sts_rdata_o(sts_rdata_o), .irq_o(irq_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // one cycle of stimulus, driven on the falling edge, results read at the next falling edge
    task automatic cyc(input logic c, input logic t, input logic cw, input logic [31:0] cd,
                       input logic sw, input logic [31:0] sd);
        @(negedge clk);
        cmpl_i = c; tick_i = t; cfg_we_i = cw; cfg_wdata_i = cd; sts_we_i = sw; sts_wdata_i = sd;
        @(negedge clk);
        cmpl_i = 0; tick_i = 0; cfg_we_i = 0; sts_we_i = 0;
    endtask

    task automatic wcfg(input logic [31:0] d); cyc(0, 0, 1, d, 0, 0); endtask
    task automatic wsts(input logic [31:0] d); cyc(0, 0, 0, 0, 1, d); endtask
    task automatic pulse_cmpl(); cyc(1, 0, 0, 0, 0, 0); endtask
    task automatic pulse_tick(); cyc(0, 1, 0, 0, 0, 0); endtask

    task automatic t_reset();
        chk("R1 cfg", cfg_rdata_o, 32'h0001_0000);
        chk("R1 sts", sts_rdata_o, 32'h0001_0000);
        chk("R1 irq", {31'd0, irq_o}, 0);
    endtask

    task automatic t_threshold();
        wcfg(32'h0003_1001);
        chk("R8 run reload", sts_rdata_o, 32'h0003_0000);
        chk("R7 cfg read", cfg_rdata_o, 32'h0003_1001);
        pulse_cmpl(); pulse_cmpl();
        chk("R2 decrement", sts_rdata_o, 32'h0001_0000);
        chk("R2 no irq yet", {31'd0, irq_o}, 0);
        pulse_cmpl();
        chk("R2 flag and reload", sts_rdata_o, 32'h0003_1000);
        chk("R5 irq high", {31'd0, irq_o}, 1);
    endtask

    task automatic t_w1c();
        wsts(32'h0000_0000);
        chk("R6 zero write keeps", sts_rdata_o, 32'h0003_1000);
        wsts(32'h0000_1000);
        chk("R6 one write clears", sts_rdata_o, 32'h0003_0000);
        chk("R6 irq low", {31'd0, irq_o}, 0);
        pulse_cmpl(); pulse_cmpl();
        cyc(1, 0, 0, 0, 1, 32'h0000_1000);
        chk("R6 set beats clear", sts_rdata_o, 32'h0003_1000);
        wsts(32'h0000_7000);
        chk("R6 clear again", sts_rdata_o, 32'h0003_0000);
    endtask

    task automatic t_mask();
        wcfg(32'h0003_0001);
        pulse_cmpl(); pulse_cmpl(); pulse_cmpl();
        chk("R5 masked flag", sts_rdata_o, 32'h0003_1000);
        chk("R5 masked irq", {31'd0, irq_o}, 0);
        wcfg(32'h0003_1000);
        chk("R5 enabled irq", {31'd0, irq_o}, 1);
        chk("R8 no run no reload", sts_rdata_o, 32'h0003_1000);
        wsts(32'h0000_1000);
    endtask

    task automatic t_run_reload();
        wcfg(32'h0006_1001);
        pulse_cmpl(); pulse_cmpl();
        wcfg(32'h0006_1000);
        chk("R8 count kept", sts_rdata_o, 32'h0004_0000);
        wcfg(32'h0006_1001);
        chk("R8 count reloaded", sts_rdata_o, 32'h0006_0000);
    endtask

    task automatic t_delay();
        wcfg(32'h040A_2001);
        pulse_cmpl();
        chk("R3 armed", sts_rdata_o, 32'h0409_0000);
        for (int i = 0; i < 3; i++) pulse_tick();
        chk("R3 counted", sts_rdata_o, 32'h0109_0000);
        chk("R3 no flag yet", {31'd0, irq_o}, 0);
        pulse_tick();
        chk("R3 expiry", sts_rdata_o, 32'h000A_2000);
        chk("R3 irq", {31'd0, irq_o}, 1);
        wsts(32'h0000_2000);
        for (int i = 0; i < 4; i++) pulse_tick();
        chk("R3 stays stopped", sts_rdata_o, 32'h000A_0000);
    endtask

    task automatic t_zero_delay();
        wcfg(32'h000A_2001);
        pulse_cmpl();
        for (int i = 0; i < 20; i++) pulse_tick();
        chk("R4 no timer", sts_rdata_o, 32'h0009_0000);
        chk("R4 no irq", {31'd0, irq_o}, 0);
        wcfg(32'h030A_2001);
        pulse_cmpl();
        wcfg(32'h000A_2000);
        pulse_cmpl();
        for (int i = 0; i < 5; i++) pulse_tick();
        chk("R4 completion stops timer", sts_rdata_o, 32'h0008_0000);
    endtask

    task automatic t_collision();
        wcfg(32'h050A_2001);
        pulse_cmpl();
        for (int i = 0; i < 4; i++) pulse_tick();
        chk("R10 timer at one", sts_rdata_o, 32'h0109_0000);
        cyc(1, 1, 0, 0, 0, 0);
        chk("R10 flag and rearm", sts_rdata_o, 32'h0509_2000);
        wsts(32'h0000_2000);
        for (int i = 0; i < 5; i++) pulse_tick();
        chk("R10 later expiry", sts_rdata_o, 32'h000A_2000);
        wsts(32'h0000_2000);
    endtask

    task automatic t_soft_reset();
        wcfg(32'h0305_1001);
        pulse_cmpl();
        chk("R9 before", sts_rdata_o, 32'h0304_0000);
        wcfg(32'h0305_1005);
        chk("R9 cfg", cfg_rdata_o, 32'h0001_0000);
        chk("R9 sts", sts_rdata_o, 32'h0001_0000);
        for (int i = 0; i < 3; i++) pulse_tick();
        chk("R9 timer stopped", sts_rdata_o, 32'h0001_0000);
        pulse_cmpl();
        chk("R9 threshold one", sts_rdata_o, 32'h0001_1000);
        chk("R9 enables off", {31'd0, irq_o}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_threshold();
        t_w1c();
        t_mask();
        t_run_reload();
        t_delay();
        t_zero_delay();
        t_collision();
        t_soft_reset();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule